// File: doc/BRIEF.md
# Interval Timer Host Register Sequencer

This block is the processor-facing register front end of a three-channel interval timer. The host side is an 8-bit data bus with a 2-bit address and separate read and write strobes. Addresses 0, 1 and 2 are the data ports of the three channels, and address 3 takes command bytes. The counting channel cores sit beside this block and are not part of it. The block gives each core a 16-bit load value with a one-cycle load strobe, plus its access type, mode and BCD flag. In return, each core supplies its live count and its output level.

A command byte does one of three things for a single channel: it reprograms the channel, it freezes the channel's count, or it acts as a multi-channel read-back command that can freeze counts and status bytes together. Data writes assemble 16-bit counts from bytes according to the channel's access type. A data read returns, in priority order, a frozen status byte, then a frozen count, and otherwise the live count. Each is served byte-wise.

Top module: `tmr_host_if`

## Requirements
- R1: After synchronous reset, every channel has access type word (3), mode 3, BCD 0, no frozen count or status, both byte sequencers at the low byte, and no load strobe. The host asserts at most one of `wr_en`/`rd_en` in a cycle, and each access takes effect on the clock edge where its strobe is high.
- R2: A command byte written to address 3 uses bits 7:6 as the channel select (0–2) and bits 5:4 as the access type (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 are the mode and bit 0 is BCD. A nonzero access type updates only the selected channel's `ch_acc`/`ch_mode`/`ch_bcd` from the next cycle on, and it restarts both of that channel's byte sequencers at the low byte. Outputs stay unchanged without such a write.
- R3: For a data write in low-only access, the channel loads `{8'h00, byte}`. In high-only access it loads `{byte, 8'h00}`. `ch_ld_stb` for that channel is high for exactly the one cycle after the write edge, with `ch_ld_val` valid in that cycle.
- R4: In word access, the first data write is only held and gives no strobe. The second write loads `{second, first}`, and the sequence then starts again.
- R5: A command byte with access type 0 freezes the selected channel's live count. The frozen value is read per the access type (word: low byte, then high byte) and is then released, so that later reads return the live count.
- R6: A count-freeze request, whether from a command byte or a read-back, is ignored while that channel's frozen count is not yet fully read. The first frozen value survives.
- R7: A read-back command (bits 7:6 = 3) selects channel n with bit 1+n. Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status. It acts on all selected channels at once.
- R8: A status byte has the channel output level in bit 7, 0 in bit 6, the access type in bits 5:4, the mode in bits 3:1 and BCD in bit 0. These values are captured at the read-back edge. A status request is ignored while an earlier status byte of that channel is unread.
- R9: A data read returns a pending status byte first, then a pending frozen count, and otherwise the live count. Each read consumes one byte of whichever source it returned.
- R10: Live-count reads return the low byte in low-only access and the high byte in high-only access. In word access they alternate between low and high, starting with low.
- R11: A read from address 3 returns 8'hFF and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address (0–2 data ports, 3 command port) |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data for the addressed port, valid while `rd_en` is high |
| ch_ld_stb | output | 3 | Per-channel one-cycle count load strobe |
| ch_ld_val | output | 48 | Per-channel 16-bit load value, channel n at bits 16n+15:16n |
| ch_acc | output | 6 | Per-channel access type, channel n at bits 2n+1:2n |
| ch_mode | output | 9 | Per-channel counting mode, channel n at bits 3n+2:3n |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_live | input | 48 | Per-channel live count from the cores, same packing as `ch_ld_val` |
| ch_out | input | 3 | Per-channel output level from the cores |

## Verification
The properties take for granted that the host never raises both strobes in one cycle. They also assume that `ch_live` and `ch_out` are stable at the edges where a freeze or status capture happens. The stimulus comes from one sequential process in which each access task raises exactly one strobe for a single cycle and drops it before the next. Live counts and output levels are changed only between accesses, so every capture sees a settled value.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LO     = 2'd1,
        ACC_HI     = 2'd2,
        ACC_WORD   = 2'd3
    } acc_e;

    // frozen-count read state; codes line up with acc_e on capture
    typedef enum logic [1:0] {
        FZ_NONE = 2'd0,
        FZ_LO   = 2'd1,
        FZ_HI   = 2'd2,
        FZ_PAIR = 2'd3
    } frz_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{acc: ACC_WORD, mode: 3'd3, bcd: 1'b0};

    function automatic logic [7:0] status_byte(input logic lvl, input ctl_t c);
        return {lvl, 1'b0, c.acc, c.mode, c.bcd};
    endfunction

endpackage

// File: rtl/tmr_cmd_dec.sv
`timescale 1ns/1ps
module tmr_cmd_dec
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output ctl_t          ctl_in,
    output logic [NCH-1:0] ctl_we,
    output logic [NCH-1:0] frz_req,
    output logic [NCH-1:0] sts_req,
    output logic [NCH-1:0] dat_we,
    output logic [NCH-1:0] dat_re
);
    logic       cmd_port;
    logic       rb_cmd;
    logic [1:0] sel;
    logic [1:0] acc_f;

    assign cmd_port = wr_en && (addr == 2'd3);
    assign sel      = wdata[7:6];
    assign acc_f    = wdata[5:4];
    assign rb_cmd   = (sel == 2'd3);
    assign ctl_in   = '{acc: acc_e'(acc_f), mode: wdata[3:1], bcd: wdata[0]};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit        = !rb_cmd && (sel == 2'(n));
        assign ctl_we[n]  = cmd_port && hit && (acc_f != 2'd0);
        assign frz_req[n] = cmd_port && ((hit && acc_f == 2'd0) ||
                                         (rb_cmd && wdata[1+n] && !wdata[5]));
        assign sts_req[n] = cmd_port && rb_cmd && wdata[1+n] && !wdata[4];
        assign dat_we[n]  = wr_en && (addr == 2'(n));
        assign dat_re[n]  = rd_en && (addr == 2'(n));
    end

endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  ctl_t          ctl_in,
    input  logic          frz_req,
    input  logic          sts_req,
    input  logic          dat_we,
    input  logic          dat_re,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] live,
    input  logic          out_lvl,
    output ctl_t          ctl,
    output logic          ld_stb,
    output logic [CW-1:0] ld_val,
    output logic [DW-1:0] rd_byte
);
    localparam int HW = CW - DW;

    logic          wr_hi;
    logic [DW-1:0] lo_hold;
    logic          rd_hi;
    frz_e          frz;
    logic [CW-1:0] frz_val;
    logic          sts_pend;
    logic [7:0]    sts_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= CTL_RESET;
            wr_hi    <= 1'b0;
            lo_hold  <= '0;
            rd_hi    <= 1'b0;
            frz      <= FZ_NONE;
            frz_val  <= '0;
            sts_pend <= 1'b0;
            sts_val  <= '0;
            ld_stb   <= 1'b0;
            ld_val   <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (ctl_we) begin
                ctl   <= ctl_in;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
            if (frz_req && frz == FZ_NONE) begin
                frz_val <= live;
                frz     <= frz_e'(ctl.acc);
            end
            if (sts_req && !sts_pend) begin
                sts_val  <= status_byte(out_lvl, ctl);
                sts_pend <= 1'b1;
            end
            if (dat_we) begin
                unique case (ctl.acc)
                    ACC_LO: begin
                        ld_stb <= 1'b1;
                        ld_val <= {{HW{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        ld_stb <= 1'b1;
                        ld_val <= {wdata[HW-1:0], {DW{1'b0}}};
                    end
                    default: begin
                        if (!wr_hi) begin
                            lo_hold <= wdata;
                            wr_hi   <= 1'b1;
                        end else begin
                            ld_stb <= 1'b1;
                            ld_val <= {wdata[HW-1:0], lo_hold};
                            wr_hi  <= 1'b0;
                        end
                    end
                endcase
            end
            if (dat_re) begin
                if (sts_pend) begin
                    sts_pend <= 1'b0;
                end else if (frz != FZ_NONE) begin
                    frz <= (frz == FZ_PAIR) ? FZ_HI : FZ_NONE;
                end else if (ctl.acc == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
        end
    end

    always_comb begin
        if (sts_pend) begin
            rd_byte = sts_val;
        end else begin
            unique case (frz)
                FZ_LO, FZ_PAIR: rd_byte = frz_val[DW-1:0];
                FZ_HI:          rd_byte = frz_val[CW-1:DW];
                default: begin
                    unique case (ctl.acc)
                        ACC_HI:   rd_byte = live[CW-1:DW];
                        ACC_WORD: rd_byte = rd_hi ? live[CW-1:DW] : live[DW-1:0];
                        default:  rd_byte = live[DW-1:0];
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/tmr_rd_mux.sv
`timescale 1ns/1ps
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]        addr,
    input  logic [NCH*DW-1:0] ch_bytes,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        rdata = '1;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = ch_bytes[i*DW +: DW];
        end
    end
endmodule

// File: rtl/tmr_host_if.sv
`timescale 1ns/1ps
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    ch_ld_stb,
    output logic [NCH*CW-1:0] ch_ld_val,
    output logic [2*NCH-1:0]  ch_acc,
    output logic [3*NCH-1:0]  ch_mode,
    output logic [NCH-1:0]    ch_bcd,
    input  logic [NCH*CW-1:0] ch_live,
    input  logic [NCH-1:0]    ch_out
);
    ctl_t              ctl_in;
    logic [NCH-1:0]    ctl_we, frz_req, sts_req, dat_we, dat_re;
    logic [NCH*DW-1:0] ch_bytes;

    tmr_cmd_dec #(.DW(DW)) i_dec (
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .ctl_in(ctl_in), .ctl_we(ctl_we), .frz_req(frz_req),
        .sts_req(sts_req), .dat_we(dat_we), .dat_re(dat_re)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ctl_t ctl;
        tmr_chan_regs #(.DW(DW), .CW(CW)) i_regs (
            .clk(clk), .rst(rst),
            .ctl_we(ctl_we[n]), .ctl_in(ctl_in),
            .frz_req(frz_req[n]), .sts_req(sts_req[n]),
            .dat_we(dat_we[n]), .dat_re(dat_re[n]),
            .wdata(wdata), .live(ch_live[n*CW +: CW]), .out_lvl(ch_out[n]),
            .ctl(ctl), .ld_stb(ch_ld_stb[n]), .ld_val(ch_ld_val[n*CW +: CW]),
            .rd_byte(ch_bytes[n*DW +: DW])
        );
        assign ch_acc[2*n +: 2]  = ctl.acc;
        assign ch_mode[3*n +: 3] = ctl.mode;
        assign ch_bcd[n]         = ctl.bcd;
    end

    tmr_rd_mux #(.DW(DW)) i_mux (
        .addr(addr), .ch_bytes(ch_bytes), .rdata(rdata)
    );

endmodule

// File: rtl/tmr_host_if_chk.sv
`timescale 1ns/1ps
module tmr_host_if_chk
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DW-1:0]     rdata,
    input logic [NCH-1:0]    ch_ld_stb,
    input logic [NCH*CW-1:0] ch_ld_val,
    input logic [2*NCH-1:0]  ch_acc,
    input logic [3*NCH-1:0]  ch_mode,
    input logic [NCH-1:0]    ch_bcd
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(wr_en && rd_en)); // R1

    AST_CTL_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 2'd3) |=> ($stable(ch_mode) && $stable(ch_acc) && $stable(ch_bcd))); // R2

    AST_CMD_PORT_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd3) |-> (rdata == {DW{1'b1}})); // R11

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && addr == 2'(n)) |=> !ch_ld_stb[n]); // R3

        AST_LOW_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
            (ch_ld_stb[n] && ch_acc[2*n +: 2] == 2'd1) |-> (ch_ld_val[n*CW+DW +: CW-DW] == '0)); // R3

        AST_HIGH_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
            (ch_ld_stb[n] && ch_acc[2*n +: 2] == 2'd2) |-> (ch_ld_val[n*CW +: DW] == '0)); // R3

        AST_ACC_NONZERO: assert property (@(posedge clk) disable iff (rst)
            ch_acc[2*n +: 2] != 2'd0); // R2
    end
endmodule

bind tmr_host_if tmr_host_if_chk #(.DW(DW), .CW(CW)) i_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .ch_ld_stb(ch_ld_stb), .ch_ld_val(ch_ld_val),
    .ch_acc(ch_acc), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
);

// File: tb/test_tmr_host_if.sv
`timescale 1ns/1ps
module test_tmr_host_if;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [2:0]  ch_ld_stb;
    logic [47:0] ch_ld_val;
    logic [5:0]  ch_acc;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [2:0]  ch_out = '0;
    int          live [NC];

    always #2.5 clk = ~clk;

    tmr_host_if i_tmr_host_if (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .ch_ld_stb(ch_ld_stb), .ch_ld_val(ch_ld_val),
        .ch_acc(ch_acc), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_live({live[2][15:0], live[1][15:0], live[0][15:0]}),
        .ch_out(ch_out)
    );

    // behavioural reference state
    int m_acc [NC], m_mode [NC], m_bcd [NC];
    int m_wrhi [NC], m_hold [NC], m_rdhi [NC];
    int m_frz [NC], m_fval [NC], m_spend [NC], m_sts [NC];
    int e_stb [NC], e_val [NC];
    int n_chk = 0, n_fail = 0;
    int last_rd;

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int c = 0; c < NC; c++) begin
            m_acc[c] = 3; m_mode[c] = 3; m_bcd[c] = 0;
            m_wrhi[c] = 0; m_hold[c] = 0; m_rdhi[c] = 0;
            m_frz[c] = 0; m_fval[c] = 0; m_spend[c] = 0; m_sts[c] = 0;
            e_stb[c] = 0; e_val[c] = 0;
        end
    endtask

    task automatic m_freeze(input int c);
        if (m_frz[c] == 0) begin
            m_fval[c] = live[c] & 16'hFFFF;
            m_frz[c]  = m_acc[c];
        end
    endtask

    task automatic m_write(input int a, input int d);
        if (a == 3) begin
            int sel = (d >> 6) & 3;
            if (sel == 3) begin
                for (int c = 0; c < NC; c++) begin
                    if (((d >> (1 + c)) & 1) == 1) begin
                        if (((d >> 5) & 1) == 0) m_freeze(c);
                        if (((d >> 4) & 1) == 0 && m_spend[c] == 0) begin
                            m_sts[c] = (int'(ch_out[c]) << 7) | (m_acc[c] << 4) |
                                       (m_mode[c] << 1) | m_bcd[c];
                            m_spend[c] = 1;
                        end
                    end
                end
            end else if (((d >> 4) & 3) == 0) begin
                m_freeze(sel);
            end else begin
                m_acc[sel] = (d >> 4) & 3; m_mode[sel] = (d >> 1) & 7;
                m_bcd[sel] = d & 1; m_wrhi[sel] = 0; m_rdhi[sel] = 0;
            end
        end else begin
            case (m_acc[a])
                1: begin e_stb[a] = 1; e_val[a] = d; end
                2: begin e_stb[a] = 1; e_val[a] = d << 8; end
                default: begin
                    if (m_wrhi[a] == 0) begin m_hold[a] = d; m_wrhi[a] = 1; end
                    else begin e_stb[a] = 1; e_val[a] = (d << 8) | m_hold[a]; m_wrhi[a] = 0; end
                end
            endcase
        end
    endtask

    task automatic m_read(input int a, output int r);
        int lv;
        if (a == 3) begin r = 8'hFF; return; end
        lv = live[a] & 16'hFFFF;
        if (m_spend[a] != 0) begin
            m_spend[a] = 0; r = m_sts[a];
        end else if (m_frz[a] != 0) begin
            r = (m_frz[a] == 2) ? (m_fval[a] >> 8) : (m_fval[a] & 8'hFF);
            m_frz[a] = (m_frz[a] == 3) ? 2 : 0;
        end else if (m_acc[a] == 1) begin
            r = lv & 8'hFF;
        end else if (m_acc[a] == 2) begin
            r = lv >> 8;
        end else begin
            r = (m_rdhi[a] != 0) ? (lv >> 8) : (lv & 8'hFF);
            m_rdhi[a] = 1 - m_rdhi[a];
        end
    endtask

    // one clock: compare every output against the model just after the edge
    task automatic tick();
        @(posedge clk);
        #1;
        for (int c = 0; c < NC; c++) begin
            chk((m_acc[c] == 3) ? "R4" : "R3", int'(ch_ld_stb[c]), e_stb[c], "load strobe");
            if (e_stb[c] != 0)
                chk((m_acc[c] == 3) ? "R4" : "R3", int'(ch_ld_val[c*16 +: 16]), e_val[c], "load value");
            chk("R2", int'(ch_acc[c*2 +: 2]), m_acc[c], "access type");
            chk("R2", int'(ch_mode[c*3 +: 3]), m_mode[c], "mode");
            chk("R2", int'(ch_bcd[c]), m_bcd[c], "bcd");
            e_stb[c] = 0;
        end
    endtask

    task automatic wr(input int a, input int d);
        addr = 2'(a); wdata = 8'(d); wr_en = 1'b1;
        m_write(a, d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        int exp;
        addr = 2'(a); rd_en = 1'b1;
        #1;
        m_read(a, exp);
        last_rd = int'(rdata);
        chk(req, last_rd, exp, "read byte");
        tick();
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) live[c] = 0;
        live[0] = 16'h1234;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        tick();
        chk("R1", int'(ch_ld_stb), 0, "reset strobes");
        chk("R1", int'(ch_acc), 6'h3F, "reset access");
        rd(0, "R1"); chk("R1", last_rd, 8'h34, "reset word read low first");
        rd(0, "R1"); chk("R1", last_rd, 8'h12, "reset word read high next");

        // R2 program channels
        wr(3, 8'h14);            // ch0 low only, mode 2
        wr(3, 8'h60);            // ch1 high only, mode 0
        wr(3, 8'hB7);            // ch2 word, mode 3, bcd
        chk("R2", int'(ch_mode), {3'd3, 3'd0, 3'd2}, "modes after programming");

        // R3 low-only and high-only loads
        wr(0, 8'h5A);
        wr(1, 8'h33);
        // R4 word load
        wr(2, 8'h34);
        tick();
        wr(2, 8'h12);

        // R10 live reads
        live[2] = 16'hBEEF; live[0] = 16'h1122; live[1] = 16'hAB01;
        rd(2, "R10"); chk("R10", last_rd, 8'hEF, "word low");
        rd(2, "R10"); chk("R10", last_rd, 8'hBE, "word high");
        rd(2, "R10");
        rd(0, "R10"); chk("R10", last_rd, 8'h22, "low only");
        rd(0, "R10");
        rd(1, "R10"); chk("R10", last_rd, 8'hAB, "high only");

        // R5 freeze ch2, then change live count
        wr(3, 8'h80);
        live[2] = 16'h0000;
        rd(2, "R5"); chk("R5", last_rd, 8'hEF, "frozen low");
        rd(2, "R5"); chk("R5", last_rd, 8'hBE, "frozen high");
        rd(2, "R5"); chk("R5", last_rd, 8'h00, "released to live");

        // R6 freeze is not re-armed while pending
        live[0] = 16'h1111;
        wr(3, 8'h00);
        live[0] = 16'h2222;
        wr(3, 8'h00);
        rd(0, "R6"); chk("R6", last_rd, 8'h11, "first freeze kept");
        rd(0, "R6"); chk("R6", last_rd, 8'h22, "live after release");

        // R7/R8/R9 read-back of ch0 and ch2, count and status
        ch_out = 3'b101;
        live[0] = 16'h4455; live[2] = 16'h6677;
        wr(3, 8'hCA);
        live[0] = 16'h0; live[2] = 16'h0;
        rd(0, "R8"); chk("R8", last_rd, 8'h94, "ch0 status byte");
        rd(0, "R9"); chk("R9", last_rd, 8'h55, "ch0 frozen after status");
        rd(0, "R9"); chk("R9", last_rd, 8'h00, "ch0 live last");
        rd(2, "R7"); chk("R7", last_rd, 8'hB7, "ch2 status byte");
        rd(2, "R7"); chk("R7", last_rd, 8'h77, "ch2 frozen low");
        rd(2, "R7"); chk("R7", last_rd, 8'h66, "ch2 frozen high");

        // R8 status-only read-back, second request ignored while pending
        ch_out = 3'b000;
        wr(3, 8'hE4);
        ch_out = 3'b010;
        wr(3, 8'hE4);
        rd(1, "R8"); chk("R8", last_rd, 8'h20, "first status kept");
        rd(1, "R8");

        // R11 command-port read changes nothing
        live[2] = 16'hC3D4;
        rd(2, "R11");
        rd(3, "R11"); chk("R11", last_rd, 8'hFF, "command port read");
        rd(2, "R11"); chk("R11", last_rd, 8'hC3, "sequence unchanged");

        // R2 reprogramming restarts both sequencers
        wr(2, 8'h99);
        rd(2, "R2");
        wr(3, 8'hB6);
        wr(2, 8'h78);
        wr(2, 8'h56);
        rd(2, "R2"); chk("R2", last_rd, 8'hD4, "read restarts at low");
        tick();

        summary();
        $finish;
    end
endmodule